// File: doc/BRIEF.md
# Half-Range Ramp TDC Readout Sequencer

This block is the digital side of a ramp-based charge readout. A conversion starts when the conversion enable rises. The sequencer first reads the comparator while the comparator is set to the half-scale reference. That single decision sets the range select output. The range select removes the fixed half-scale delay from the delay line or leaves it in, and it also supplies the top bit of the result.

After the range select is locked, the read enable rises. One cycle later, a set/reset window latch opens the ramp window: begin goes high and end goes low. The analog ramp and the delay line run while the window is open. The comparator now watches the full-scale reference. When it trips, the latch closes the window and freezes a snapshot of the delay-line taps. The snapshot goes through XORs on adjacent taps and a lowest-index priority pick, which gives the five fine bits. The block then presents the result with a one-cycle valid strobe and returns everything to rest.

Top module: `hrtdc_readout`

## Requirements
- R1: While reset is high and in the first cycle after it, range_sel, read_en, ramp_begin, ramp_end and code_valid are 0 and code is 0.
- R2: The comparator is sampled on the third rising edge at which conv_en is seen high in idle (a two-cycle settle). range_sel takes that sampled value and holds it until the conversion releases.
- R3: read_en rises exactly one cycle after range_sel is locked, and ramp_begin rises exactly one cycle after read_en.
- R4: While the window is open, ramp_begin is 1 and ramp_end is 0. The two are never high together.
- R5: A comparator high seen while the window is open closes it on that edge (ramp_end 1, ramp_begin 0) and captures the taps on that same edge. Tap changes after that edge do not alter the result.
- R6: Bit 5 of code is the inverse of the range_sel value used in that conversion (1 means the long range).
- R7: For a clean thermometer snapshot with n ones starting at tap 0 (1 ≤ n ≤ 31), code[4:0] equals n.
- R8: An all-zero snapshot gives code[4:0] = 0. An all-one snapshot saturates code[4:0] to 31.
- R9: A snapshot with several tap transitions resolves to i+1, where i is the lowest index with taps[i] ≠ taps[i+1].
- R10: code_valid is a single-cycle pulse, one cycle after ramp_end rises. code holds its value until the next pulse.
- R11: In the code_valid cycle, read_en, ramp_end and range_sel are already 0. A held-high conv_en starts no new conversion until it has been seen low.
- R12: Comparator activity while idle changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Conversion enable, level |
| cmp_out | input | 1 | Comparator output (half-scale, then full-scale) |
| taps | input | 32 | Delay-line tap states, tap 0 first |
| range_sel | output | 1 | 1: short range, half-scale delay bypassed |
| read_en | output | 1 | Readout enable after range lock |
| ramp_begin | output | 1 | Window open: ramp and delay line running |
| ramp_end | output | 1 | Window closed: taps frozen |
| code | output | 6 | Result: {long range, fine position} |
| code_valid | output | 1 | One-cycle result strobe |

## Verification
The hardest condition to reach is a snapshot that changes right after capture. The check has to show that the result comes from the taps present on the closing edge and from nothing later. To get there, the stimulus drives the intended pattern and the comparator trip on the same falling edge. On the next falling edge it inverts every tap. Bubbled snapshots, saturation patterns, idle comparator toggles and a conv_en held high past the end of a conversion are driven as directed cases. Randomized ramp lengths, ranges and thermometer depths cover the rest.

// File: rtl/hrtdc_pkg.sv
package hrtdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALF,
        ST_ARM,
        ST_SETB,
        ST_RUN,
        ST_ENC,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic range_sel;
        logic read_en;
        logic win_set;
        logic win_stop;
        logic release_all;
        logic enc_fire;
    } seq_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/hrtdc_edge_encoder.sv
module hrtdc_edge_encoder #(
    parameter int unsigned TAPS   = 32,
    parameter int unsigned FINE_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]   snap,
    output logic [FINE_W-1:0] fine
);
    localparam int unsigned NX = TAPS - 1;

    logic [NX-1:0] edge_x;

    // one XOR per adjacent tap pair
    for (genvar g = 0; g < NX; g++) begin : g_xor
        assign edge_x[g] = snap[g] ^ snap[g+1];
    end

    // lowest set marker wins; no marker saturates by tap 0
    always_comb begin
        fine = snap[0] ? '1 : '0;
        for (int i = NX - 1; i >= 0; i--) begin
            if (edge_x[i]) fine = FINE_W'(i + 1);
        end
    end

endmodule

// File: rtl/hrtdc_window_latch.sv
module hrtdc_window_latch #(
    parameter int unsigned TAPS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            win_set,
    input  logic            win_stop,
    input  logic            release_all,
    input  logic [TAPS-1:0] taps,
    output logic            ramp_begin,
    output logic            ramp_end,
    output logic [TAPS-1:0] snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_begin <= 1'b0;
            ramp_end   <= 1'b0;
            snap       <= '0;
        end else if (release_all) begin
            ramp_begin <= 1'b0;
            ramp_end   <= 1'b0;
        end else if (win_set) begin
            ramp_begin <= 1'b1;
            ramp_end   <= 1'b0;
        end else if (win_stop && ramp_begin) begin
            ramp_begin <= 1'b0;
            ramp_end   <= 1'b1;
            snap       <= taps;
        end
    end

    // R4: window states are exclusive
    p_window_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(ramp_begin && ramp_end));

    // R5: window closes only from an open window
    p_end_from_open_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ramp_end) |-> $past(ramp_begin));

endmodule

// File: rtl/hrtdc_sequencer.sv
module hrtdc_sequencer
    import hrtdc_pkg::*;
#(
    parameter int unsigned SETTLE = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     conv_en,
    input  logic     cmp_out,
    output seq_ctl_t ctl
);
    localparam int unsigned CW = cnt_width(SETTLE);

    seq_state_e    state;
    logic [CW-1:0] settle_cnt;
    logic          rs_q;
    logic          rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            settle_cnt <= '0;
            rs_q       <= 1'b0;
            rd_q       <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    settle_cnt <= '0;
                    if (conv_en) state <= ST_HALF;
                end
                ST_HALF: begin
                    if (settle_cnt == CW'(SETTLE - 1)) begin
                        rs_q  <= cmp_out;
                        state <= ST_ARM;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_ARM: begin
                    rd_q  <= 1'b1;
                    state <= ST_SETB;
                end
                ST_SETB: state <= ST_RUN;
                ST_RUN:  if (cmp_out) state <= ST_ENC;
                ST_ENC: begin
                    rd_q  <= 1'b0;
                    rs_q  <= 1'b0;
                    state <= ST_DONE;
                end
                ST_DONE: if (!conv_en) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.range_sel   = rs_q;
        ctl.read_en     = rd_q;
        ctl.win_set     = (state == ST_SETB);
        ctl.win_stop    = (state == ST_RUN) && cmp_out;
        ctl.release_all = (state == ST_ENC);
        ctl.enc_fire    = (state == ST_ENC);
    end

    // R2: range decision stays frozen while the readout is enabled
    p_range_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_q && $past(rd_q)) |-> $stable(rs_q));

    // R11: no conversion restarts straight out of the done state
    p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_DONE) |-> (state == ST_DONE || state == ST_IDLE));

endmodule

// File: rtl/hrtdc_readout.sv
module hrtdc_readout
    import hrtdc_pkg::*;
#(
    parameter int unsigned TAPS   = 32,
    parameter int unsigned SETTLE = 2,
    parameter int unsigned FINE_W = $clog2(TAPS),
    parameter int unsigned CODE_W = FINE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_en,
    input  logic              cmp_out,
    input  logic [TAPS-1:0]   taps,
    output logic              range_sel,
    output logic              read_en,
    output logic              ramp_begin,
    output logic              ramp_end,
    output logic [CODE_W-1:0] code,
    output logic              code_valid
);
    seq_ctl_t          ctl;
    logic [TAPS-1:0]   snap;
    logic [FINE_W-1:0] fine;

    hrtdc_sequencer #(.SETTLE(SETTLE)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .conv_en (conv_en),
        .cmp_out (cmp_out),
        .ctl     (ctl)
    );

    hrtdc_window_latch #(.TAPS(TAPS)) u_win (
        .clk         (clk),
        .rst         (rst),
        .win_set     (ctl.win_set),
        .win_stop    (ctl.win_stop),
        .release_all (ctl.release_all),
        .taps        (taps),
        .ramp_begin  (ramp_begin),
        .ramp_end    (ramp_end),
        .snap        (snap)
    );

    hrtdc_edge_encoder #(.TAPS(TAPS), .FINE_W(FINE_W)) u_enc (
        .snap (snap),
        .fine (fine)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code       <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= ctl.enc_fire;
            if (ctl.enc_fire) code <= {~ctl.range_sel, fine};
        end
    end

    assign range_sel = ctl.range_sel;
    assign read_en   = ctl.read_en;

    // R3: window opens only after the readout enable was already up
    p_begin_after_read_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ramp_begin) |-> $past(read_en));

    // R6: top code bit reflects the range chosen in that conversion
    p_msb_range_r6: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> (code[CODE_W-1] == !$past(range_sel)));

    // R10: strobe is a single cycle that follows window close
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid);
    p_valid_after_end_r10: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> $past(ramp_end));

    // R11: everything is released when the result is presented
    p_release_r11: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> (!read_en && !ramp_end && !range_sel));

endmodule

// File: tb/test_hrtdc_readout.sv
module test_hrtdc_readout;
    logic        clk = 1'b0;
    logic        rst;
    logic        conv_en;
    logic        cmp_out;
    logic [31:0] taps;
    logic        range_sel, read_en, ramp_begin, ramp_end, code_valid;
    logic [5:0]  code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hrtdc_readout i_hrtdc_readout (
        .clk(clk), .rst(rst), .conv_en(conv_en), .cmp_out(cmp_out), .taps(taps),
        .range_sel(range_sel), .read_en(read_en), .ramp_begin(ramp_begin),
        .ramp_end(ramp_end), .code(code), .code_valid(code_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_code(input bit above, input logic [31:0] t);
        logic [4:0] f;
        f = t[0] ? 5'd31 : 5'd0;
        for (int i = 30; i >= 0; i--) if (t[i] != t[i+1]) f = 5'(i + 1);
        return {~above, f};
    endfunction

    function automatic logic [31:0] therm(input int n);
        logic [63:0] v;
        v = (64'd1 << n) - 64'd1;
        return v[31:0];
    endfunction

    task automatic convert(input bit above, input logic [31:0] t, input int ramp, input bit hold_en);
        logic [5:0] e;
        e = exp_code(above, t);
        @(negedge clk); conv_en = 1'b1; cmp_out = above;
        repeat (3) @(negedge clk);
        chk(range_sel == above, "R2 range lock", {31'd0, range_sel}, {31'd0, above});
        chk(!read_en, "R3 read_en before lock", {31'd0, read_en}, 0);
        cmp_out = 1'b0;
        @(negedge clk);
        chk(read_en && !ramp_begin, "R3 read_en then begin", {30'd0, read_en, ramp_begin}, 32'h2);
        @(negedge clk);
        chk(ramp_begin && !ramp_end, "R4 window open", {30'd0, ramp_begin, ramp_end}, 32'h2);
        for (int k = 0; k < ramp; k++) begin
            @(negedge clk);
            chk(ramp_begin && !ramp_end && range_sel == above, "R4 window held",
                {29'd0, ramp_begin, ramp_end, range_sel}, {29'd0, 2'b10, above});
        end
        taps = t; cmp_out = 1'b1;
        @(negedge clk);
        chk(ramp_end && !ramp_begin && !code_valid, "R5 window close",
            {29'd0, ramp_begin, ramp_end, code_valid}, 32'h2);
        taps = ~t; cmp_out = 1'b0;
        @(negedge clk);
        chk(code_valid, "R10 strobe", {31'd0, code_valid}, 1);
        chk(code == e, "R7 R8 R9 R5 code", {26'd0, code}, {26'd0, e});
        chk(code[5] == ~above, "R6 msb", {31'd0, code[5]}, {31'd0, ~above});
        chk(!read_en && !ramp_end && !range_sel, "R11 release",
            {29'd0, read_en, ramp_end, range_sel}, 0);
        @(negedge clk);
        chk(!code_valid && code == e, "R10 single pulse and hold", {25'd0, code_valid, code}, {26'd0, e});
        if (hold_en) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                cmp_out = k[0];
                chk(!read_en && !range_sel && !ramp_begin, "R11 held enable no restart",
                    {29'd0, read_en, range_sel, ramp_begin}, 0);
            end
            cmp_out = 1'b0;
        end
        conv_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] held;
        rst = 1'b1; conv_en = 1'b0; cmp_out = 1'b0; taps = '0;
        repeat (3) @(negedge clk);
        chk({range_sel, read_en, ramp_begin, ramp_end, code_valid} == 0 && code == 0,
            "R1 reset", {21'd0, range_sel, read_en, ramp_begin, ramp_end, code_valid, code}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({range_sel, read_en, ramp_begin, ramp_end, code_valid} == 0 && code == 0,
            "R1 after reset", {21'd0, range_sel, read_en, ramp_begin, ramp_end, code_valid, code}, 0);

        // directed corners
        convert(1'b1, therm(5), 3, 1'b0);          // R7
        convert(1'b0, therm(31), 1, 1'b0);         // R7 top of clean range
        convert(1'b0, 32'h0, 2, 1'b0);             // R8 all zero
        convert(1'b1, 32'hFFFF_FFFF, 4, 1'b0);     // R8 all one
        convert(1'b0, 32'h0000_005F, 2, 1'b0);     // R9 bubble: 0..4 set, 5 clear, 6 set
        convert(1'b1, 32'hFFFF_FFFE, 0, 1'b0);     // R9 tap 0 low, edge at 0
        convert(1'b1, therm(1), 5, 1'b1);          // R11 hold enable

        // R12: comparator toggles while idle
        held = code;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cmp_out = ~cmp_out;
            taps = 32'(k * 32'h1111_1111);
            chk(!read_en && !ramp_begin && !ramp_end && !code_valid && !range_sel && code == held,
                "R12 idle comparator", {20'd0, read_en, ramp_begin, ramp_end, code_valid, range_sel, 1'b0, code},
                {26'd0, held});
        end
        cmp_out = 1'b0;

        void'($urandom(32'd1234));
        for (int it = 0; it < 40; it++) begin
            int n;
            n = $urandom % 33;
            convert(1'($urandom % 2), (n == 32) ? 32'hFFFF_FFFF : therm(n),
                    int'($urandom % 12), 1'($urandom % 4 == 0));
        end

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule